// File: doc/BRIEF.md
# TLB Refill Page-Table Walker

This block services a translation miss by loading one page-table entry from memory and installing it in the refill ways of a TLB. On a miss pulse it captures the faulting virtual address, its miss cause and a probe flag. It then forms the virtual address of the page-table entry from a base register and the faulting address, and translates that address through a lookup port. The lookup is a read at the most privileged level and never starts a second walk.

After a hit the walker issues one 32-bit read over a request/acknowledge handshake. It then writes the entry into a refill way picked by a rotating counter, together with the entry index and page number taken from the faulting address. In the same cycle it writes the faulting address to the exception-address register. A lookup that fails ends the walk at once with the captured miss cause flagged as a fault. In probe mode the walker fetches and reports the entry but changes neither the TLB, the exception-address register nor the way counter.

Top module: `ptw_refill_walker`

## Requirements
- R1: The lookup address is (pt_base OR (faulting address shifted right by 10)) with bits 1:0 forced to 0, and it is presented on xl_vaddr while xl_req is high.
- R2: When the lookup misses (xl_hit low while xl_req is high), the walk ends with done and fault high and fault_cause equal to the captured miss cause. No memory read, TLB write or exception-address write takes place.
- R3: After a lookup hit, mem_req rises with mem_addr equal to xl_paddr and stays high with a steady address until mem_ack. mem_rdata is captured in the acknowledge cycle.
- R4: The installed ring (tlbw_ring, and res_ring in the result) is bits 5:4 of the fetched entry, and the fetched entry appears unchanged on tlbw_pte and res_pte.
- R5: A refill increments a 2-bit counter and uses the new value as the way. Refills after reset therefore go to ways 1, 2, 3, 0, 1 in turn.
- R6: Asynchronous reset clears the way counter and leaves xl_req, mem_req, tlbw_en, excv_we and done low.
- R7: A successful non-probe walk pulses excv_we for one cycle with excv_vaddr equal to the faulting address, in the same cycle as tlbw_en.
- R8: tlbw_idx is bits 13:12 of the faulting address and tlbw_vpn is bits 31:14.
- R9: With miss_probe set, the walk returns the entry on res_pte/res_ring with fault low and res_way 0. It makes no TLB or exception-address write and leaves the way counter unchanged.
- R10: done is a single-cycle pulse. A miss_valid that arrives while a walk is in progress is ignored.
- R11: A successful walk reports fault low and res_way equal to the way written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss pulse, starts a walk when idle |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_cause | input | 6 | Cause code of the original miss |
| miss_probe | input | 1 | Probe: fetch without installing |
| pt_base | input | 32 | Page-table base register |
| xl_req | output | 1 | Lookup request |
| xl_vaddr | output | 32 | Entry virtual address to translate |
| xl_hit | input | 1 | Lookup succeeded (same cycle) |
| xl_paddr | input | 32 | Translated entry address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read acknowledge with data |
| mem_rdata | input | 32 | Read data |
| tlbw_en | output | 1 | TLB write strobe |
| tlbw_way | output | 2 | Refill way |
| tlbw_idx | output | 2 | Entry index in the way |
| tlbw_vpn | output | 18 | Virtual page number tag |
| tlbw_pte | output | 32 | Entry written |
| tlbw_ring | output | 2 | Ring of the mapping |
| excv_we | output | 1 | Exception-address write strobe |
| excv_vaddr | output | 32 | Exception-address value |
| done | output | 1 | Walk finished pulse |
| fault | output | 1 | Walk failed |
| fault_cause | output | 6 | Cause on fault, else 0 |
| res_pte | output | 32 | Fetched entry |
| res_ring | output | 2 | Ring of fetched entry |
| res_way | output | 2 | Way written (0 in probe) |

## Verification
The hardest case to reach is the wrap of the refill way from 3 back to 0 with a probe walk in the middle, because only completed non-probe walks move the counter. The stimulus table orders successful, probe and faulting walks so that the wrap falls after a probe and a fault. A reset in the middle of the run then checks that the count starts again at way 1. A second miss pulse is injected while a read is still waiting for its acknowledge, which checks that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XLATE = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } ptw_state_e;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
  parameter int VA_W       = 32,
  parameter int PTE_SHIFT  = 10,
  parameter int ALIGN_W    = 2,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 2,
  localparam int VPN_W     = VA_W - PAGE_SHIFT - IDX_W,
  localparam int IDX_OW    = (IDX_W > 0) ? IDX_W : 1
) (
  input  logic [VA_W-1:0]   base_i,
  input  logic [VA_W-1:0]   vaddr_i,
  output logic [VA_W-1:0]   pte_va_o,
  output logic [IDX_OW-1:0] idx_o,
  output logic [VPN_W-1:0]  vpn_o
);
  localparam logic [VA_W-1:0] ALIGN_MASK = {{(VA_W-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};

  assign pte_va_o = (base_i | (vaddr_i >> PTE_SHIFT)) & ALIGN_MASK;
  assign vpn_o    = vaddr_i[VA_W-1 -: VPN_W];

  generate
    if (IDX_W > 0) begin : g_idx
      assign idx_o = vaddr_i[PAGE_SHIFT +: IDX_W];
    end else begin : g_noidx
      assign idx_o = '0;
    end
  endgenerate
endmodule

// File: rtl/ptw_way_sel.sv
module ptw_way_sel #(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o
);
  logic [WAY_W-1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + 1'b1;
  assign way_o = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_d;
  end

  assert_way_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (way_o == WAY_W'($past(way_o) + 1'b1)));
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid_i,
  input  logic [VA_W-1:0]    miss_vaddr_i,
  input  logic [CAUSE_W-1:0] miss_cause_i,
  input  logic               miss_probe_i,
  input  logic               xl_hit_i,
  input  logic [VA_W-1:0]    xl_paddr_i,
  input  logic               mem_ack_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               xl_req_o,
  output logic               mem_req_o,
  output logic [VA_W-1:0]    mem_addr_o,
  output logic               wr_phase_o,
  output logic               write_state_o,
  output logic               done_o,
  output logic               fault_o,
  output logic               probe_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [VA_W-1:0]    vaddr_o,
  output logic [DATA_W-1:0]  pte_o
);
  ptw_state_e state_q, state_d;
  logic [VA_W-1:0]    vaddr_q, paddr_q;
  logic [DATA_W-1:0]  pte_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               probe_q, fault_q, fault_d;
  logic               start, xl_ok, mem_take;

  assign start    = (state_q == ST_IDLE) && miss_valid_i;
  assign xl_ok    = (state_q == ST_XLATE) && xl_hit_i;
  assign mem_take = (state_q == ST_READ) && mem_ack_i;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_IDLE:  if (miss_valid_i) begin state_d = ST_XLATE; fault_d = 1'b0; end
      ST_XLATE: begin
        if (xl_hit_i) state_d = ST_READ;
        else begin state_d = ST_DONE; fault_d = 1'b1; end
      end
      ST_READ:  if (mem_ack_i) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      cause_q <= '0;
      probe_q <= 1'b0;
    end else if (start) begin
      vaddr_q <= miss_vaddr_i;
      cause_q <= miss_cause_i;
      probe_q <= miss_probe_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     paddr_q <= '0;
    else if (xl_ok) paddr_q <= xl_paddr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pte_q <= '0;
    else if (mem_take) pte_q <= mem_rdata_i;
  end

  assign xl_req_o      = (state_q == ST_XLATE);
  assign mem_req_o     = (state_q == ST_READ);
  assign mem_addr_o    = paddr_q;
  assign write_state_o = (state_q == ST_WRITE);
  assign wr_phase_o    = (state_q == ST_WRITE) && !probe_q;
  assign done_o        = (state_q == ST_DONE);
  assign fault_o       = fault_q;
  assign probe_o       = probe_q;
  assign cause_o       = cause_q;
  assign vaddr_o       = vaddr_q;
  assign pte_o         = pte_q;

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_lookup_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req_o && !xl_hit_i) |=> (done_o && fault_o && !mem_req_o));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ptw_refill_walker.sv
module ptw_refill_walker #(
  parameter int VA_W       = 32,
  parameter int DATA_W     = 32,
  parameter int CAUSE_W    = 6,
  parameter int PTE_SHIFT  = 10,
  parameter int ALIGN_W    = 2,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 2,
  parameter int WAY_W      = 2,
  parameter int RING_LSB   = 4,
  parameter int RING_W     = 2,
  localparam int VPN_W     = VA_W - PAGE_SHIFT - IDX_W,
  localparam int IDX_OW    = (IDX_W > 0) ? IDX_W : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [VA_W-1:0]    miss_vaddr,
  input  logic [CAUSE_W-1:0] miss_cause,
  input  logic               miss_probe,
  input  logic [VA_W-1:0]    pt_base,
  output logic               xl_req,
  output logic [VA_W-1:0]    xl_vaddr,
  input  logic               xl_hit,
  input  logic [VA_W-1:0]    xl_paddr,
  output logic               mem_req,
  output logic [VA_W-1:0]    mem_addr,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               tlbw_en,
  output logic [WAY_W-1:0]   tlbw_way,
  output logic [IDX_OW-1:0]  tlbw_idx,
  output logic [VPN_W-1:0]   tlbw_vpn,
  output logic [DATA_W-1:0]  tlbw_pte,
  output logic [RING_W-1:0]  tlbw_ring,
  output logic               excv_we,
  output logic [VA_W-1:0]    excv_vaddr,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] fault_cause,
  output logic [DATA_W-1:0]  res_pte,
  output logic [RING_W-1:0]  res_ring,
  output logic [WAY_W-1:0]   res_way
);
  logic               wr_phase, write_state, probe_q, fault_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [VA_W-1:0]    vaddr_q;
  logic [DATA_W-1:0]  pte_q;
  logic [WAY_W-1:0]   way_next, res_way_q;

  ptw_ctrl #(.VA_W(VA_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid_i(miss_valid), .miss_vaddr_i(miss_vaddr),
    .miss_cause_i(miss_cause), .miss_probe_i(miss_probe),
    .xl_hit_i(xl_hit), .xl_paddr_i(xl_paddr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xl_req_o(xl_req), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .wr_phase_o(wr_phase), .write_state_o(write_state), .done_o(done),
    .fault_o(fault_q), .probe_o(probe_q), .cause_o(cause_q),
    .vaddr_o(vaddr_q), .pte_o(pte_q)
  );

  ptw_addr_calc #(.VA_W(VA_W), .PTE_SHIFT(PTE_SHIFT), .ALIGN_W(ALIGN_W),
                  .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)) calc_i (
    .base_i(pt_base), .vaddr_i(vaddr_q),
    .pte_va_o(xl_vaddr), .idx_o(tlbw_idx), .vpn_o(tlbw_vpn)
  );

  ptw_way_sel #(.WAY_W(WAY_W)) way_i (
    .clk(clk), .rst_n(rst_n), .adv_i(wr_phase), .way_o(way_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           res_way_q <= '0;
    else if (write_state) res_way_q <= probe_q ? '0 : way_next;
  end

  assign tlbw_en     = wr_phase;
  assign tlbw_way    = way_next;
  assign tlbw_pte    = pte_q;
  assign tlbw_ring   = pte_q[RING_LSB +: RING_W];
  assign excv_we     = wr_phase;
  assign excv_vaddr  = vaddr_q;
  assign fault       = fault_q;
  assign fault_cause = fault_q ? cause_q : '0;
  assign res_pte     = pte_q;
  assign res_ring    = pte_q[RING_LSB +: RING_W];
  assign res_way     = res_way_q;

  assert_excv_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    excv_we |-> $past(mem_ack));
  assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tlbw_en |=> (done && !fault));
endmodule

// File: tb/ptw_refill_walker_tb.sv
module ptw_refill_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        miss_valid, miss_probe;
  logic [31:0] miss_vaddr, pt_base;
  logic [5:0]  miss_cause;
  logic        xl_req, xl_hit, xl_fail;
  logic [31:0] xl_vaddr, xl_paddr;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        tlbw_en, excv_we, done, fault;
  logic [1:0]  tlbw_way, tlbw_idx, tlbw_ring, res_ring, res_way;
  logic [17:0] tlbw_vpn;
  logic [31:0] tlbw_pte, excv_vaddr, res_pte;
  logic [5:0]  fault_cause;

  localparam logic [31:0] XL_FLIP = 32'h6000_0000;
  assign xl_hit   = xl_req & ~xl_fail;
  assign xl_paddr = xl_vaddr ^ XL_FLIP;

  ptw_refill_walker dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_cause(miss_cause), .miss_probe(miss_probe), .pt_base(pt_base),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_hit(xl_hit), .xl_paddr(xl_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tlbw_en(tlbw_en), .tlbw_way(tlbw_way), .tlbw_idx(tlbw_idx), .tlbw_vpn(tlbw_vpn),
    .tlbw_pte(tlbw_pte), .tlbw_ring(tlbw_ring), .excv_we(excv_we),
    .excv_vaddr(excv_vaddr), .done(done), .fault(fault), .fault_cause(fault_cause),
    .res_pte(res_pte), .res_ring(res_ring), .res_way(res_way)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic        probe;
    logic        xlfail;
    logic [3:0]  dly;
    logic [5:0]  cause;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0040_3000, 32'hC000_0000, 1'b0, 1'b0, 4'd0, 6'd16},
    '{32'hDEAD_B123, 32'h8000_0000, 1'b0, 1'b0, 4'd3, 6'd16},
    '{32'h1234_5678, 32'h0000_0000, 1'b1, 1'b0, 4'd1, 6'd16},
    '{32'hFFFF_FFFF, 32'hFFC0_0000, 1'b0, 1'b1, 4'd0, 6'd24},
    '{32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'd2, 6'd16},
    '{32'h7654_3210, 32'h4000_0000, 1'b0, 1'b0, 4'd0, 6'd16},
    '{32'hABCD_E000, 32'h2000_0000, 1'b0, 1'b0, 4'd5, 6'd16},
    '{32'h0000_2FFC, 32'h0012_3457, 1'b1, 1'b0, 4'd0, 6'd8}
  };

  int n_chk = 0, n_fail = 0;
  logic [1:0] exp_cnt;

  function automatic logic [31:0] pte_of(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0000_5A30;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; miss_valid = 1'b0; mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = 2'd0;
    @(negedge clk);
  endtask

  task automatic walk(input vec_t v, input logic inject);
    logic [31:0] exp_pva, exp_pte, seen_xl, seen_mem, w_pte, x_va;
    logic [1:0]  w_way, w_idx, w_ring;
    logic [17:0] w_vpn;
    int n_xl, n_mem, n_w, n_x, req_cyc, cyc;
    logic got_done, injected;
    exp_pva = (v.base | (v.va >> 10)) & 32'hFFFF_FFFC;
    exp_pte = pte_of(exp_pva ^ XL_FLIP);
    n_xl = 0; n_mem = 0; n_w = 0; n_x = 0; req_cyc = 0; got_done = 0; injected = 0;
    seen_xl = '0; seen_mem = '0; w_pte = '0; x_va = '0; w_way = '0; w_idx = '0;
    w_ring = '0; w_vpn = '0;
    xl_fail = v.xlfail;
    miss_vaddr = v.va; pt_base = v.base; miss_probe = v.probe; miss_cause = v.cause;
    miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    cyc = 0;
    while (!got_done && cyc < 40) begin
      mem_ack = 1'b0;
      miss_valid = 1'b0;
      if (xl_req) begin n_xl++; seen_xl = xl_vaddr; end
      if (mem_req) begin
        n_mem++; seen_mem = mem_addr;
        if (inject && !injected) begin
          miss_valid = 1'b1; miss_vaddr = 32'h5555_0000; miss_probe = 1'b0;
          injected = 1;
        end
        if (req_cyc == int'(v.dly)) begin
          mem_ack = 1'b1; mem_rdata = pte_of(mem_addr);
        end else begin
          mem_rdata = 32'hDEAD_DEAD;
        end
        req_cyc++;
      end
      if (tlbw_en) begin
        n_w++; w_way = tlbw_way; w_idx = tlbw_idx; w_vpn = tlbw_vpn;
        w_pte = tlbw_pte; w_ring = tlbw_ring;
      end
      if (excv_we) begin n_x++; x_va = excv_vaddr; end
      if (done) begin
        got_done = 1;
        chk(n_xl == 1 && seen_xl == exp_pva, "R1 lookup address", seen_xl, exp_pva);
        if (v.xlfail) begin
          chk(fault && fault_cause == v.cause, "R2 fault cause", {26'd0, fault_cause},
              {26'd0, v.cause});
          chk(n_mem == 0 && n_w == 0 && n_x == 0, "R2 no side effects",
              n_mem + n_w + n_x, 0);
        end else begin
          chk(seen_mem == (exp_pva ^ XL_FLIP) && n_mem == int'(v.dly) + 1,
              "R3 memory read held", seen_mem, exp_pva ^ XL_FLIP);
          chk(res_pte == exp_pte && res_ring == exp_pte[5:4], "R4 result entry/ring",
              res_pte, exp_pte);
          chk(!fault, "R11 no fault", {31'd0, fault}, 0);
          if (v.probe) begin
            chk(n_w == 0 && n_x == 0 && res_way == 2'd0, "R9 probe no write",
                n_w + n_x, 0);
          end else begin
            exp_cnt = exp_cnt + 2'd1;
            chk(n_w == 1 && w_way == exp_cnt, "R5 refill way", {30'd0, w_way},
                {30'd0, exp_cnt});
            chk(res_way == exp_cnt, "R11 result way", {30'd0, res_way}, {30'd0, exp_cnt});
            chk(w_pte == exp_pte && w_ring == exp_pte[5:4], "R4 written entry ring",
                {30'd0, w_ring}, {30'd0, exp_pte[5:4]});
            chk(w_idx == v.va[13:12] && w_vpn == v.va[31:14], "R8 index and vpn",
                {12'd0, w_vpn, w_idx}, {12'd0, v.va[31:14], v.va[13:12]});
            chk(n_x == 1 && x_va == v.va, "R7 exception address", x_va, v.va);
          end
        end
      end
      @(negedge clk);
      cyc++;
    end
    mem_ack = 1'b0; miss_valid = 1'b0;
    chk(got_done, "R10 walk completes", {31'd0, got_done}, 1);
    chk(!done, "R10 done single pulse", {31'd0, done}, 0);
    if (inject) begin
      repeat (2) @(negedge clk);
      chk(!xl_req && !mem_req && !done, "R10 busy miss ignored",
          {29'd0, xl_req, mem_req, done}, 0);
    end
  endtask

  int wd_cyc = 0;
  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", wd_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    xl_fail = 1'b0; mem_rdata = '0; miss_vaddr = '0; pt_base = '0;
    miss_probe = 1'b0; miss_cause = '0;
    do_reset();
    // R6: reset state
    chk(!xl_req && !mem_req && !tlbw_en && !excv_we && !done, "R6 reset outputs idle",
        {27'd0, xl_req, mem_req, tlbw_en, excv_we, done}, 0);
    for (int i = 0; i < NVEC; i++) walk(VECS[i], 1'b0);
    // R10: second miss during an outstanding read
    walk(VECS[6], 1'b1);
    // R5/R6: counter restarts after reset, first refill to way 1
    do_reset();
    walk(VECS[1], 1'b0);
    walk(VECS[5], 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule